// File: doc/BRIEF.md
# Logic and Shift Unit

This block is the logical half of a small processor's execute stage. Each cycle it can accept one operation on two operands. It forms the bitwise combinations, moves a single operand one place left or right, or compares the operands. It also has an operation that probes the condition bits it holds. Shifts take the bit that enters the vacated end from a caller-supplied fill input, so the same operation serves logical shifts (fill 0) and set-fill shifts (fill 1). Rotates wrap the departing bit around instead.

Results and condition bits are captured when the start strobe is high. A valid strobe follows one cycle later. Compare and flag-test change only the condition bits. The held result stays as it was, so a later instruction can still consume it.

Top module: `logic_shift_unit`

## Requirements
- R1: During reset (rst_n low at a clock edge), the result, the flags and valid all clear to zero.
- R2: Op code 0 gives A AND B. Op code 1 gives A OR B. Op code 2 gives A XOR B. Op code 3 gives NOT A. Each result is written to the result register.
- R3: Op code 4 (shift toward LSB) writes A moved right by one place, with the fill input entering the MSB. The carry flag takes the old LSB.
- R4: Op code 5 (shift toward MSB) writes A moved left by one place, with the fill input entering the LSB. The carry flag takes the old MSB.
- R5: Op code 6 rotates A right by one place, and the old LSB appears at the MSB. Op code 7 rotates A left by one place, and the old MSB appears at the LSB. In both cases the carry flag takes the bit that wrapped, and the count of one bits is kept.
- R6: The flags vector is {sign (bit 2), carry (bit 1), zero (bit 0)}. Op codes 0 to 7 set zero when the new result is all zeros and set sign to the new result's MSB. Op codes 0 to 3 clear carry.
- R7: Op code 8 (compare) leaves the result unchanged. It sets zero when A equals B, sets carry when A is below B (unsigned), and sets sign to the MSB of A minus B modulo 2^WIDTH.
- R8: Op code 9 (flag test) leaves the result unchanged. It sets zero when the held flags ANDed with the 3-bit mask are all zeros, and keeps carry and sign.
- R9: valid is high for exactly the cycle after each edge that sees start high. With start low, the result and flags hold.
- R10: Op codes 10 to 15 leave the result and flags unchanged, and valid still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the operation at this edge |
| op | input | 4 | Operation code |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| fill | input | 1 | Bit inserted by shifts |
| mask | input | 3 | Flag-select mask for the test operation |
| result | output | WIDTH | Registered result |
| flags | output | 3 | Registered {sign, carry, zero} |
| valid | output | 1 | One-cycle strobe after a captured operation |

## Verification
The embedded properties watch some rules on every cycle. They check that valid follows start by one cycle, that the result holds for idle, compare, test and unused codes, that test keeps carry and sign, that the sign bit tracks the result MSB, and that rotates keep the bit count. Only the scoreboard scenarios can show the exact values. These cover fill insertion at either end, the carry taken from the departing bit, the unsigned ordering on compare, the zero flag for masked tests, and the reset contents. A reference model in the bench supplies the expected values.

// File: rtl/lsu_pkg.sv
// Shared constants and operation encoding for the logic and shift unit.
// Assumes a 4-bit op field and a 3-bit flags vector {sign, carry, zero}.
package lsu_pkg;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 3;
    localparam int FLG_Z  = 0;
    localparam int FLG_C  = 1;
    localparam int FLG_S  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_XOR = 4'd2,
        OP_NOT = 4'd3,
        OP_SHR = 4'd4,
        OP_SHL = 4'd5,
        OP_ROR = 4'd6,
        OP_ROL = 4'd7,
        OP_CMP = 4'd8,
        OP_TST = 4'd9
    } lsu_op_e;

    // True for op codes that write the result register.
    function automatic logic op_writes_result(input logic [OP_W-1:0] code);
        return code <= 4'd7;
    endfunction

    // True for op codes that form a bitwise result (carry cleared).
    function automatic logic op_is_bitwise(input logic [OP_W-1:0] code);
        return code <= 4'd3;
    endfunction
endpackage

// File: rtl/lsu_bitwise.sv
// Bitwise combiner: forms AND, OR, XOR of two operands and NOT of the first.
// Purely combinational; the selector picks one of the four forms by the
// low two bits of the op code.
module lsu_bitwise #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);
    // Per-bit selection of the requested logic function.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            case (sel)
                2'd0:    y[i] = a[i] & b[i];
                2'd1:    y[i] = a[i] | b[i];
                2'd2:    y[i] = a[i] ^ b[i];
                default: y[i] = ~a[i];
            endcase
        end
    end
endmodule

// File: rtl/lsu_shift1.sv
// One-place mover in a fixed direction chosen by TOWARD_MSB.
// With rotate low, the fill bit enters the vacated end. With rotate high, the
// departing bit wraps around. out_bit always reports the departing bit.
module lsu_shift1 #(
    parameter int WIDTH      = 8,
    parameter bit TOWARD_MSB = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic             fill,
    input  logic             rotate,
    output logic [WIDTH-1:0] y,
    output logic             out_bit
);
    logic entry;

    if (TOWARD_MSB) begin : g_left
        // Move toward MSB; old MSB departs, entry lands at LSB.
        always_comb begin
            out_bit = a[WIDTH-1];
            entry   = rotate ? a[WIDTH-1] : fill;
            y       = {a[WIDTH-2:0], entry};
        end
    end else begin : g_right
        // Move toward LSB; old LSB departs, entry lands at MSB.
        always_comb begin
            out_bit = a[0];
            entry   = rotate ? a[0] : fill;
            y       = {entry, a[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/lsu_compare.sv
// Unsigned comparator: forms A - B modulo 2^WIDTH with a borrow out.
// Combinational; the difference is used only for flags.
module lsu_compare #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] diff,
    output logic             borrow,
    output logic             equal
);
    logic [WIDTH:0] wide;

    // Extended subtraction; the top bit is the borrow.
    always_comb begin
        wide   = {1'b0, a} - {1'b0, b};
        diff   = wide[WIDTH-1:0];
        borrow = wide[WIDTH];
        equal  = (a == b);
    end
endmodule

// File: rtl/logic_shift_unit.sv
// Logic and shift unit: bitwise ops, one-place shifts and rotates with a
// caller fill bit, compare and flag test. Result and flags are registered on
// a start edge; valid follows one cycle later. Assumes WIDTH >= 2.
module logic_shift_unit
    import lsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    input  logic              fill,
    input  logic [FLAG_W-1:0] mask,
    output logic [WIDTH-1:0]  result,
    output logic [FLAG_W-1:0] flags,
    output logic              valid
);
    logic [WIDTH-1:0]  bw_y, shr_y, shl_y, cmp_diff;
    logic              shr_out, shl_out, cmp_borrow, cmp_eq;
    logic              is_rotate;
    logic [WIDTH-1:0]  result_q, next_res;
    logic [FLAG_W-1:0] flags_q, next_flg;
    logic              valid_q;

    assign is_rotate = op[1];

    lsu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a(opa), .b(opb), .sel(op[1:0]), .y(bw_y)
    );

    lsu_shift1 #(.WIDTH(WIDTH), .TOWARD_MSB(1'b0)) u_right (
        .a(opa), .fill(fill), .rotate(is_rotate), .y(shr_y), .out_bit(shr_out)
    );

    lsu_shift1 #(.WIDTH(WIDTH), .TOWARD_MSB(1'b1)) u_left (
        .a(opa), .fill(fill), .rotate(is_rotate), .y(shl_y), .out_bit(shl_out)
    );

    lsu_compare #(.WIDTH(WIDTH)) u_cmp (
        .a(opa), .b(opb), .diff(cmp_diff), .borrow(cmp_borrow), .equal(cmp_eq)
    );

    // Select next result and flags from the operation code.
    always_comb begin
        next_res = result_q;
        next_flg = flags_q;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                next_res        = bw_y;
                next_flg[FLG_C] = 1'b0;
            end
            OP_SHR, OP_ROR: begin
                next_res        = shr_y;
                next_flg[FLG_C] = shr_out;
            end
            OP_SHL, OP_ROL: begin
                next_res        = shl_y;
                next_flg[FLG_C] = shl_out;
            end
            OP_CMP: begin
                next_flg[FLG_Z] = cmp_eq;
                next_flg[FLG_C] = cmp_borrow;
                next_flg[FLG_S] = cmp_diff[WIDTH-1];
            end
            OP_TST: begin
                next_flg[FLG_Z] = ((flags_q & mask) == '0);
            end
            default: ;
        endcase
        if (op_writes_result(op)) begin
            next_flg[FLG_Z] = (next_res == '0);
            next_flg[FLG_S] = next_res[WIDTH-1];
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= start;
            if (start) begin
                result_q <= next_res;
                flags_q  <= next_flg;
            end
        end
    end

    assign result = result_q;
    assign flags  = flags_q;
    assign valid  = valid_q;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    // R9
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!valid && $stable(result) && $stable(flags)));
    // R7
    cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_CMP) |=> $stable(result));
    // R8
    tst_keeps_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_TST) |=> ($stable(result) && $stable(flags[FLG_C])
                                     && $stable(flags[FLG_S])));
    // R6
    sign_tracks_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op <= 4'd7) |=> (flags[FLG_S] == result[WIDTH-1]));
    // R5
    rotate_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == OP_ROR || op == OP_ROL))
            |=> ($countones(result) == $countones($past(opa))));
    // R10
    unused_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op >= 4'd10) |=> ($stable(result) && $stable(flags) && valid));
endmodule

// File: tb/logic_shift_unit_tb.sv
// Scoreboard bench: the driver computes expected values from a model of the
// requirements and queues them; a monitor compares on every valid strobe.
module logic_shift_unit_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   op = '0;
    logic [W-1:0] opa = '0, opb = '0;
    logic         fill = 1'b0;
    logic [2:0]   mask = '0;
    logic [W-1:0] result;
    logic [2:0]   flags;
    logic         valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_res;
    logic [2:0]   m_flg;
    logic [W+2:0] exp_q[$];
    string        tag_q[$];

    always #4 clk = ~clk;

    logic_shift_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .fill(fill), .mask(mask), .result(result), .flags(flags), .valid(valid)
    );

    task automatic check(input string req, input logic [W+2:0] act,
                         input logic [W+2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual res/flags %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare each strobed output against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
                check("R9", {result, flags}, 'x);
            end else begin
                check(tag_q.pop_front(), {result, flags}, exp_q.pop_front());
            end
        end
    end

    // Driver: model the operation, queue the expectation, apply for one edge.
    task automatic issue(input string req, input logic [3:0] c,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic f, input logic [2:0] m);
        logic [W-1:0] r;
        logic [2:0]   fl;
        logic [W:0]   d;
        r  = m_res;
        fl = m_flg;
        case (c)
            4'd0: begin r = a & b; fl[1] = 1'b0; end
            4'd1: begin r = a | b; fl[1] = 1'b0; end
            4'd2: begin r = a ^ b; fl[1] = 1'b0; end
            4'd3: begin r = ~a;    fl[1] = 1'b0; end
            4'd4: begin r = {f, a[W-1:1]};    fl[1] = a[0];   end
            4'd5: begin r = {a[W-2:0], f};    fl[1] = a[W-1]; end
            4'd6: begin r = {a[0], a[W-1:1]}; fl[1] = a[0];   end
            4'd7: begin r = {a[W-2:0], a[W-1]}; fl[1] = a[W-1]; end
            4'd8: begin
                d  = {1'b0, a} - {1'b0, b};
                fl = {d[W-1], (a < b), (a == b)};
            end
            4'd9: fl[0] = ((m_flg & m) == 3'b000);
            default: ;
        endcase
        if (c <= 4'd7) begin
            fl[0] = (r == '0);
            fl[2] = r[W-1];
        end
        m_res = r;
        m_flg = fl;
        exp_q.push_back({r, fl});
        tag_q.push_back(req);
        start = 1'b1; op = c; opa = a; opb = b; fill = f; mask = m;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_res = '0;
        m_flg = '0;
        repeat (3) @(negedge clk);
        // R1: reset contents
        check("R1", {result, flags}, '0);
        checks++;
        if (valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual valid %b expected 0", valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R6: bitwise forms, back to back
        issue("R2", 4'd0, 8'hA5, 8'h3C, 1'b0, 3'b0);
        issue("R2", 4'd1, 8'hA5, 8'h3C, 1'b0, 3'b0);
        issue("R6", 4'd2, 8'hA5, 8'hA5, 1'b0, 3'b0);
        issue("R2", 4'd3, 8'h0F, 8'h00, 1'b0, 3'b0);
        // R3: right shift with fill 0 and 1
        issue("R3", 4'd4, 8'h81, 8'h00, 1'b0, 3'b0);
        issue("R3", 4'd4, 8'h02, 8'h00, 1'b1, 3'b0);
        // R4: left shift, including a zero result with carry out
        issue("R4", 4'd5, 8'h81, 8'h00, 1'b0, 3'b0);
        issue("R4", 4'd5, 8'h7F, 8'h00, 1'b1, 3'b0);
        issue("R4", 4'd5, 8'h80, 8'h00, 1'b0, 3'b0);
        // R2: bitwise clears the carry left by the shift
        issue("R2", 4'd1, 8'h40, 8'h01, 1'b0, 3'b0);
        // R5: rotates ignore fill
        issue("R5", 4'd6, 8'h01, 8'h00, 1'b0, 3'b0);
        issue("R5", 4'd7, 8'h80, 8'h00, 1'b0, 3'b0);
        issue("R5", 4'd7, 8'h5A, 8'h00, 1'b1, 3'b0);
        issue("R5", 4'd6, 8'hB4, 8'h00, 1'b1, 3'b0);
        idle(2);
        // R7: compare below, equal, above
        issue("R7", 4'd8, 8'h10, 8'h20, 1'b0, 3'b0);
        // R8: carry set -> masked carry nonzero, zero clear
        issue("R8", 4'd9, 8'h00, 8'h00, 1'b0, 3'b010);
        issue("R8", 4'd9, 8'h00, 8'h00, 1'b0, 3'b001);
        issue("R7", 4'd8, 8'h33, 8'h33, 1'b0, 3'b0);
        issue("R7", 4'd8, 8'h40, 8'h10, 1'b0, 3'b0);
        issue("R8", 4'd9, 8'h00, 8'h00, 1'b0, 3'b111);
        // R10: unused codes hold everything
        issue("R6", 4'd3, 8'h7E, 8'h00, 1'b0, 3'b0);
        issue("R10", 4'd12, 8'hFF, 8'h00, 1'b1, 3'b111);
        issue("R10", 4'd15, 8'h00, 8'hFF, 1'b0, 3'b0);
        idle(3);
        // R9: idle inputs move nothing and valid stays low
        opa = 8'hFF; op = 4'd3;
        idle(3);
        check("R9", {result, flags}, {m_res, m_flg});
        checks++;
        if (valid !== 1'b0) begin
            fails++;
            $display("FAIL R9: actual valid %b expected 0", valid);
        end
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule